// File: doc/BRIEF.md
# Endpoint Interrupt Status Aggregator

This block keeps the interrupt status of every endpoint of a USB device controller, one register per IN endpoint and one per OUT endpoint. The core reports events as single-cycle pulses on two event buses. Each pulse sets a sticky status bit. Software clears a status bit by writing a one to it.

Each endpoint also has a mask register with the same layout. The masked status of an endpoint is reduced to one bit of a read-only summary word, which holds one bit per endpoint and direction. The summary is then reduced to two core interrupt flags, one for IN and one for OUT.

A plain register port reaches all of this state. It has a synchronous write strobe and a combinational read. Software normally reads the summary first, then the status of the flagged endpoint, and then clears that status.

Top module: `ep_irq_agg`

## Requirements
- R1: After reset every status register, every mask register and the summary word read 0, and `irq_in_o` and `irq_out_o` are low.
- R2: The event bus carries 7 lanes per endpoint, and lane k of endpoint n sits at bus bit n*7+k. One cycle after a pulse on a lane, the status bit for that lane is set. The lane-to-bit mapping is:
  - lane 0 (transmit underrun) sets bit 8;
  - lane 1 (OUT packet error) sets bit 8;
  - lane 2 (buffer not ready) sets bit 9;
  - lane 3 (packet dropped) sets bit 11;
  - lane 4 (babble) sets bit 12;
  - lane 5 (NAK) sets bit 13;
  - lane 6 (NYET) sets bit 14.
- R3: Status bits 31:15 and 10, and bits 7:0, always read 0, and writing ones to them has no effect.
- R4: A register write to a status register clears exactly those status bits whose write data bit is 1. Every other bit is kept.
- R5: When an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Status bit 11 (packet dropped) never contributes to the summary or to either interrupt flag, whatever the mask holds.
- R7: The summary word reads at offset 0x818 and is read-only. Bit n is IN endpoint n and bit 16+n is OUT endpoint n. Each summary bit is the OR over bits 14, 13, 12, 9 and 8 of status AND mask for that endpoint.
- R8: An event on the wrong direction is ignored. Lane 0 on an OUT endpoint does not change its status, and neither does lane 1 on an IN endpoint.
- R9: `irq_in_o` is the OR of summary bits 15:0 and `irq_out_o` is the OR of bits 31:16. Clearing the last active status bit of an endpoint drops both its summary bit and the matching flag.
- R10: The address map is as follows:
  - IN status of endpoint n is at 0x908 + n*0x20;
  - OUT status of endpoint n is at 0xB08 + n*0x20;
  - each mask register sits 4 bytes above its status register.
  Only mask bits 14, 13, 12, 9 and 8 are writable. All other mask bits, and any unmapped address, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_evt_i | input | NUM_EP*7 | Event pulses for IN endpoints, 7 lanes each |
| out_evt_i | input | NUM_EP*7 | Event pulses for OUT endpoints, 7 lanes each |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| summary_o | output | 2*NUM_EP | All-endpoint summary word |
| irq_in_o | output | 1 | Global IN endpoint interrupt |
| irq_out_o | output | 1 | Global OUT endpoint interrupt |

## Verification
The bench aims at these corners:
- An event and a clear that land on the same bit in the same cycle. A design that lets the clear win silently loses the event.
- A dropped-packet event with every mask bit set. A design that routes bit 11 into the reduction raises a spurious interrupt.
- Direction-specific lanes driven on the wrong direction. A design that shares lane 0 and lane 1 across directions sets bit 8 where it must stay clear.
- A partial clear must leave the neighbouring bits alone.
- Writes of all ones to status and mask registers. These expose reserved bits that a design wrongly stores.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int EVW       = 7;
  localparam int NUM_EP_DEF = 16;
  localparam int STRIDE    = 32;

  localparam logic [AW-1:0] IN_STAT_BASE  = 12'h908;
  localparam logic [AW-1:0] OUT_STAT_BASE = 12'hB08;
  localparam logic [AW-1:0] MASK_OFS      = 12'h004;
  localparam logic [AW-1:0] SUM_ADDR      = 12'h818;

  // event lanes
  localparam int EV_UNDR = 0;
  localparam int EV_PERR = 1;
  localparam int EV_BNR  = 2;
  localparam int EV_DROP = 3;
  localparam int EV_BABL = 4;
  localparam int EV_NAK  = 5;
  localparam int EV_NYET = 6;

  // status bit positions
  localparam int B_DIR  = 8;
  localparam int B_BNR  = 9;
  localparam int B_DROP = 11;
  localparam int B_BABL = 12;
  localparam int B_NAK  = 13;
  localparam int B_NYET = 14;

  localparam logic [DW-1:0] STAT_VALID = 32'h0000_7B00;
  localparam logic [DW-1:0] MASK_VALID = 32'h0000_7300;
  localparam logic [DW-1:0] IRQ_BITS   = 32'h0000_7300;

  function automatic logic [DW-1:0] evt_to_set(input logic [EVW-1:0] e, input logic is_in);
    logic [DW-1:0] s;
    s         = '0;
    s[B_DIR]  = is_in ? e[EV_UNDR] : e[EV_PERR];
    s[B_BNR]  = e[EV_BNR];
    s[B_DROP] = e[EV_DROP];
    s[B_BABL] = e[EV_BABL];
    s[B_NAK]  = e[EV_NAK];
    s[B_NYET] = e[EV_NYET];
    return s;
  endfunction

  function automatic logic ep_active(input logic [DW-1:0] stat, input logic [DW-1:0] mask);
    return |(stat & mask & IRQ_BITS);
  endfunction

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base, input int n);
    return base + AW'(n * STRIDE);
  endfunction
endpackage

// File: rtl/ep_status_reg.sv
module ep_status_reg
  import ep_irq_pkg::*;
#(
  parameter bit IS_IN = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] evt_i,
  input  logic           stat_we_i,
  input  logic           mask_we_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  stat_o,
  output logic [DW-1:0]  mask_o,
  output logic           active_o
);
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] stat_q;
  logic [DW-1:0] mask_q;

  assign set_vec = evt_to_set(evt_i, IS_IN);
  assign clr_vec = stat_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr_vec) | set_vec) & STAT_VALID;
      if (mask_we_i) mask_q <= wdata_i & MASK_VALID;
    end
  end

  assign stat_o   = stat_q;
  assign mask_o   = mask_q;
  assign active_o = ep_active(stat_q, mask_q);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we_i && ((wdata_i & ~set_vec & STAT_VALID) != '0))
      |=> ((stat_q & $past(wdata_i & ~set_vec)) == '0));

  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~(32'h1 << B_DROP)) == '0) |-> !active_o);

  generate
    if (IS_IN) begin : g_in_chk
      assert_wrong_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[EV_PERR] && !evt_i[EV_UNDR] && !stat_we_i) |=> $stable(stat_q[B_DIR]));
    end else begin : g_out_chk
      assert_wrong_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[EV_UNDR] && !evt_i[EV_PERR] && !stat_we_i) |=> $stable(stat_q[B_DIR]));
    end
  endgenerate
endmodule

// File: rtl/ep_reg_decode.sv
module ep_reg_decode
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = NUM_EP_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                addr_i,
  input  logic                         wr_i,
  input  logic [NUM_EP-1:0][DW-1:0]    in_stat_i,
  input  logic [NUM_EP-1:0][DW-1:0]    in_mask_i,
  input  logic [NUM_EP-1:0][DW-1:0]    out_stat_i,
  input  logic [NUM_EP-1:0][DW-1:0]    out_mask_i,
  input  logic [2*NUM_EP-1:0]          summary_i,
  output logic [NUM_EP-1:0]            in_stat_we_o,
  output logic [NUM_EP-1:0]            in_mask_we_o,
  output logic [NUM_EP-1:0]            out_stat_we_o,
  output logic [NUM_EP-1:0]            out_mask_we_o,
  output logic [DW-1:0]                rdata_o
);
  logic stat_hit;
  logic mask_hit;

  always_comb begin
    in_stat_we_o  = '0;
    in_mask_we_o  = '0;
    out_stat_we_o = '0;
    out_mask_we_o = '0;
    rdata_o       = '0;
    stat_hit      = 1'b0;
    mask_hit      = 1'b0;
    if (addr_i == SUM_ADDR) rdata_o = DW'(summary_i);
    for (int n = 0; n < NUM_EP; n++) begin
      if (addr_i == slot_addr(IN_STAT_BASE, n)) begin
        in_stat_we_o[n] = wr_i;
        rdata_o         = in_stat_i[n];
        stat_hit        = 1'b1;
      end
      if (addr_i == slot_addr(IN_STAT_BASE, n) + MASK_OFS) begin
        in_mask_we_o[n] = wr_i;
        rdata_o         = in_mask_i[n];
        mask_hit        = 1'b1;
      end
      if (addr_i == slot_addr(OUT_STAT_BASE, n)) begin
        out_stat_we_o[n] = wr_i;
        rdata_o          = out_stat_i[n];
        stat_hit         = 1'b1;
      end
      if (addr_i == slot_addr(OUT_STAT_BASE, n) + MASK_OFS) begin
        out_mask_we_o[n] = wr_i;
        rdata_o          = out_mask_i[n];
        mask_hit         = 1'b1;
      end
    end
  end

  assert_rsvd_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> ((rdata_o & ~STAT_VALID) == '0));

  assert_mask_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hit |-> ((rdata_o & ~MASK_VALID) == '0));

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_stat_we_o, in_mask_we_o, out_stat_we_o, out_mask_we_o}) <= 1);
endmodule

// File: rtl/ep_irq_agg.sv
module ep_irq_agg
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = NUM_EP_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EP*EVW-1:0] in_evt_i,
  input  logic [NUM_EP*EVW-1:0] out_evt_i,
  input  logic                  reg_wr_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [DW-1:0]         reg_wdata_i,
  output logic [DW-1:0]         reg_rdata_o,
  output logic [2*NUM_EP-1:0]   summary_o,
  output logic                  irq_in_o,
  output logic                  irq_out_o
);
  logic [NUM_EP-1:0][DW-1:0] in_stat, in_mask, out_stat, out_mask;
  logic [NUM_EP-1:0]         in_stat_we, in_mask_we, out_stat_we, out_mask_we;
  logic [NUM_EP-1:0]         in_active, out_active;

  ep_reg_decode #(.NUM_EP(NUM_EP)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (reg_addr_i),
    .wr_i         (reg_wr_i),
    .in_stat_i    (in_stat),
    .in_mask_i    (in_mask),
    .out_stat_i   (out_stat),
    .out_mask_i   (out_mask),
    .summary_i    (summary_o),
    .in_stat_we_o (in_stat_we),
    .in_mask_we_o (in_mask_we),
    .out_stat_we_o(out_stat_we),
    .out_mask_we_o(out_mask_we),
    .rdata_o      (reg_rdata_o)
  );

  generate
    for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
      ep_status_reg #(.IS_IN(1'b1)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (in_evt_i[n*EVW +: EVW]),
        .stat_we_i(in_stat_we[n]),
        .mask_we_i(in_mask_we[n]),
        .wdata_i  (reg_wdata_i),
        .stat_o   (in_stat[n]),
        .mask_o   (in_mask[n]),
        .active_o (in_active[n])
      );
      ep_status_reg #(.IS_IN(1'b0)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (out_evt_i[n*EVW +: EVW]),
        .stat_we_i(out_stat_we[n]),
        .mask_we_i(out_mask_we[n]),
        .wdata_i  (reg_wdata_i),
        .stat_o   (out_stat[n]),
        .mask_o   (out_mask[n]),
        .active_o (out_active[n])
      );
    end
  endgenerate

  assign summary_o = {out_active, in_active};
  assign irq_in_o  = |in_active;
  assign irq_out_o = |out_active;

  // a flag can only fall after a register write (events only ever set bits)
  assert_in_fall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_in_o) |-> $past(reg_wr_i));
  assert_out_fall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out_o) |-> $past(reg_wr_i));
endmodule

// File: tb/ep_irq_agg_tb.sv
module ep_irq_agg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEP = 16;
  localparam int EW  = 7;
  localparam int NV  = 9;
  localparam int WATCHDOG = 20000;

  // {dir_in, ep, lane, mask, exp_status, exp_irq}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 4'd0,  3'd5, 16'h2000, 16'h2000, 1'b1},
    {1'b1, 4'd3,  3'd0, 16'h0100, 16'h0100, 1'b1},
    {1'b1, 4'd15, 3'd6, 16'h0000, 16'h4000, 1'b0},
    {1'b0, 4'd0,  3'd1, 16'h0100, 16'h0100, 1'b1},
    {1'b0, 4'd7,  3'd3, 16'h7300, 16'h0800, 1'b0},
    {1'b0, 4'd9,  3'd0, 16'h7FFF, 16'h0000, 1'b0},
    {1'b1, 4'd5,  3'd1, 16'hFFFF, 16'h0000, 1'b0},
    {1'b0, 4'd15, 3'd2, 16'h0200, 16'h0200, 1'b1},
    {1'b1, 4'd8,  3'd4, 16'h1000, 16'h1000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NEP*EW-1:0] in_evt = '0, out_evt = '0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2*NEP-1:0] summary;
  logic irq_in, irq_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  ep_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .in_evt_i(in_evt), .out_evt_i(out_evt),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .summary_o(summary), .irq_in_o(irq_in), .irq_out_o(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [11:0] st_addr(input logic dir_in, input int ep);
    return (dir_in ? 12'h908 : 12'hB08) + 12'(ep * 32);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic dir_in, input int ep, input int lane);
    @(negedge clk);
    if (dir_in) in_evt[ep*EW+lane] = 1'b1; else out_evt[ep*EW+lane] = 1'b1;
    @(negedge clk);
    in_evt = '0; out_evt = '0;
  endtask

  initial begin
    logic [31:0] d;
    logic dir;
    logic [3:0] ep;
    logic [2:0] lane;
    logic [15:0] msk, exps;
    logic expirq;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(st_addr(1'b1, 0), d);  check("R1 in status ep0", d, 0);
    rd(st_addr(1'b0, 15), d); check("R1 out status ep15", d, 0);
    rd(st_addr(1'b1, 4) + 12'h4, d); check("R1 in mask ep4", d, 0);
    rd(12'h818, d); check("R1 summary", d, 0);
    check("R1 flags", {30'b0, irq_out, irq_in}, 0);

    // table walk: R2 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      {dir, ep, lane, msk, exps, expirq} = VEC[v];
      wr(st_addr(dir, int'(ep)) + 12'h4, {16'h0, msk});
      pulse(dir, int'(ep), int'(lane));
      rd(st_addr(dir, int'(ep)), d);
      check($sformatf("R2/R6/R8 vec%0d status", v), d, {16'h0, exps});
      check($sformatf("R9 vec%0d flags", v), {30'b0, irq_out, irq_in},
            dir ? {30'b0, 1'b0, expirq} : {30'b0, expirq, 1'b0});
      rd(12'h818, d);
      check($sformatf("R7 vec%0d summary", v), d,
            expirq ? (32'h1 << (int'(ep) + (dir ? 0 : 16))) : 32'h0);
      wr(st_addr(dir, int'(ep)), 32'hFFFF_FFFF);
      wr(st_addr(dir, int'(ep)) + 12'h4, 32'h0);
    end

    // R3 / R10: reserved bits and mask layout
    for (int k = 0; k < EW; k++) pulse(1'b1, 2, k);
    rd(st_addr(1'b1, 2), d); check("R3 in ep2 all lanes", d, 32'h0000_7B00);
    wr(st_addr(1'b1, 2) + 12'h4, 32'hFFFF_FFFF);
    rd(st_addr(1'b1, 2) + 12'h4, d); check("R10 mask writable bits", d, 32'h0000_7300);
    rd(12'h818, d); check("R7 summary bit2", d, 32'h0000_0004);
    check("R9 irq_in set", {31'b0, irq_in}, 1);

    // R4 partial clear
    wr(st_addr(1'b1, 2), 32'hFFFF_2000);
    rd(st_addr(1'b1, 2), d); check("R4 partial clear", d, 32'h0000_5B00);

    // R5 set wins over same-cycle clear
    @(negedge clk);
    in_evt[2*EW+5] = 1'b1;
    reg_wr = 1'b1; reg_addr = st_addr(1'b1, 2); reg_wdata = 32'h0000_2100;
    @(negedge clk);
    in_evt = '0; reg_wr = 1'b0;
    rd(st_addr(1'b1, 2), d); check("R5 set wins", d, 32'h0000_7A00);

    // R9 full clear drops summary and flag
    wr(st_addr(1'b1, 2), 32'h0000_7B00);
    rd(st_addr(1'b1, 2), d); check("R4 full clear", d, 0);
    rd(12'h818, d); check("R9 summary cleared", d, 0);
    check("R9 irq_in cleared", {31'b0, irq_in}, 0);

    // R10 OUT endpoint and unmapped address
    wr(st_addr(1'b0, 4) + 12'h4, 32'h0000_0200);
    pulse(1'b0, 4, 2);
    rd(12'h818, d); check("R7 out ep4 summary", d, 32'h0010_0000);
    check("R9 irq_out", {30'b0, irq_out, irq_in}, 32'h2);
    rd(12'h90A, d); check("R10 unmapped read", d, 0);
    wr(12'h818, 32'hFFFF_FFFF);
    rd(12'h818, d); check("R7 summary read-only", d, 32'h0010_0000);
    rd(st_addr(1'b1, 0), d); check("R3 ignored write elsewhere", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule